// File: doc/BRIEF.md
# Synchronous Burst SRAM Slave

This block is a synthesizable model of a flow-through synchronous burst SRAM. Its contents are a small internal array of words. Each word is split into byte lanes, and every lane carries eight data bits plus one parity bit. On every rising clock edge the block samples the following inputs:

- the address,
- three chip enables,
- two address strobes (a processor strobe and a controller strobe),
- an advance input,
- the write controls.

On each edge it either loads a new external address or steps a 2-bit burst counter through a four-word block. A strap input picks the burst order: linear or interleaved. Reads are flow-through: the word at the address registered at the last edge appears on `dout` combinationally.

A qualified output-enable signal, `dout_en`, stands in for a three-state pad. It is low in all of these cases:

- while the asynchronous output enable `oe_n` is high,
- while the device is deselected,
- in the cycle after a write edge,
- in the first cycle after the device leaves the deselected state.

A sleep input freezes all activity and keeps the memory contents.

A controller uses the block by placing an address and pulsing one strobe. It then either holds the burst position with `adv_n` high or steps it with `adv_n` low. Writes are made with a global write, or with byte writes qualified by a byte-write enable.

Top module: `sburst_sram`

## Requirements
- R1: A start edge has a strobe recognised and `ce1_n` low, `ce2` high and `ce3_n` low. Such an edge loads `addr` as the current address. If the block was deselected before that edge, `dout_en` is low for the following cycle. After the next edge with `adv_n` high, `dout` shows the word at `addr` with `dout_en` high (with `oe_n` low).
- R2: When `adsp_n` and `adsc_n` are both low with `ce1_n` low, only the processor strobe acts. An edge started by the processor strobe is always a read, and `gw_n`/`bwe_n` are ignored on that edge.
- R3: `adsp_n` is ignored while `ce1_n` is high. With `adsc_n` high, such an edge continues the current burst. With `adsc_n` low, the controller strobe acts and the device deselects.
- R4: After reset, and after a strobe edge with any chip enable inactive, the block is deselected: `dout_en` stays low, including across edges with `adv_n` low, until the next start edge.
- R5: `ce2` and `ce3_n` matter only on strobe edges. Changing them between strobes does not disturb a burst.
- R6: With `mode_ilv` low, a burst from low address bits s visits (s+k) mod 4 after k advances, inside the same four-word block. It wraps to s after the fourth advance.
- R7: With `mode_ilv` high, the burst visits s XOR k after k advances.
- R8: `gw_n` low on a write-capable edge writes all 36 bits, whatever `bw_n` holds.
- R9: With `gw_n` high and `bwe_n` low, lane i (bits 9i+8 down to 9i, parity bit on top) is written exactly when `bw_n[i]` is low. With `gw_n` and `bwe_n` both high, nothing is written.
- R10: `dout_en` is low in the cycle after any edge that wrote at least one lane.
- R11: `oe_n` high forces `dout_en` low at once, without waiting for a clock edge.
- R12: While `sleep` is high, `dout_en` is low and edges change nothing: no write, no address load and no advance. The burst position and the contents are intact afterwards.
- R13: A controller-strobe start edge with write controls writes the loaded address. A continuing edge writes the address reached on that edge, which is the advanced address when `adv_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| addr | input | ADDR_W | External word address |
| ce1_n | input | 1 | Chip enable 1, active low, also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep, active high |
| mode_ilv | input | 1 | Burst order strap: 0 linear, 1 interleaved |
| din | input | LANES*LANE_BITS | Write data |
| dout | output | LANES*LANE_BITS | Flow-through read data |
| dout_en | output | 1 | Read data valid to drive onto the bus |

## Verification
The assertions check the output masking rules on every cycle:

- `dout_en` falls after any lane write,
- `dout_en` falls after a deselecting strobe,
- `dout_en` falls after a start from the deselected state,
- `dout_en` follows `oe_n`.

They also check that the address and activity state freeze across sleep edges, and that a burst never leaves its four-word block. Only the bench scenarios, compared against a reference array, can show the data itself:

- the visiting order of linear and interleaved bursts from every offset, including the wrap,
- which lanes a byte mask writes,
- that a processor-strobe edge or a sleeping edge leaves memory untouched.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

   // Kind of work decided for one clock edge.
   typedef enum logic [1:0] {
      EV_IDLE  = 2'd0,   // nothing happens (deselected or asleep)
      EV_LOAD  = 2'd1,   // strobe with device selected: new address
      EV_DROP  = 2'd2,   // strobe with device not selected: deselect
      EV_STEP  = 2'd3    // active burst continues (hold or advance)
   } edge_ev_t;

endpackage

// File: rtl/sburst_seq.sv
module sburst_seq
   import sburst_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int CNT_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              ce3_n,
   input  logic              adsp_n,
   input  logic              adsc_n,
   input  logic              adv_n,
   input  logic              ilv,
   output logic              wr_ok,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              act,
   output logic              wake
);

   localparam int HI_W = ADDR_W - CNT_W;

   logic              p_go;
   logic              c_go;
   logic              sel_ok;
   edge_ev_t          ev;
   logic [HI_W-1:0]   base_q;
   logic [CNT_W-1:0]  start_q;
   logic [CNT_W-1:0]  step_q;
   logic [CNT_W-1:0]  step_d;
   logic [CNT_W-1:0]  lo_d;
   logic              act_q;
   logic              wake_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] eff;

   // Strobe arbitration: the processor strobe needs ce1_n low and wins a tie.
   assign p_go   = ~adsp_n & ~ce1_n;
   assign c_go   = ~adsc_n & ~p_go;
   assign sel_ok = ~ce1_n & ce2 & ~ce3_n;

   always_comb begin
      if (sleep)
         ev = EV_IDLE;
      else if (p_go | c_go)
         ev = sel_ok ? EV_LOAD : EV_DROP;
      else if (act_q)
         ev = EV_STEP;
      else
         ev = EV_IDLE;
   end

   // Burst position: step count combined with the loaded low bits.
   assign step_d = adv_n ? step_q : step_q + CNT_W'(1);

   generate
      if (CNT_W == 1) begin : g_order_1
         assign lo_d = start_q ^ step_d;
      end else begin : g_order_n
         assign lo_d = ilv ? (start_q ^ step_d) : CNT_W'(start_q + step_d);
      end
   endgenerate

   always_comb begin
      case (ev)
         EV_LOAD: eff = addr;
         default: eff = {base_q, lo_d};
      endcase
   end

   // A processor-strobe start is always a read.
   assign wr_ok   = ((ev == EV_LOAD) & c_go) | (ev == EV_STEP);
   assign wr_addr = eff;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         wake_q  <= 1'b0;
         base_q  <= '0;
         start_q <= '0;
         step_q  <= '0;
         cur_q   <= '0;
      end else begin
         case (ev)
            EV_LOAD: begin
               act_q   <= 1'b1;
               wake_q  <= ~act_q;
               base_q  <= addr[ADDR_W-1:CNT_W];
               start_q <= addr[CNT_W-1:0];
               step_q  <= '0;
               cur_q   <= addr;
            end
            EV_DROP: begin
               act_q  <= 1'b0;
               wake_q <= 1'b0;
            end
            EV_STEP: begin
               step_q <= step_d;
               cur_q  <= eff;
               wake_q <= 1'b0;
            end
            default: begin
               if (!sleep) wake_q <= 1'b0;
            end
         endcase
      end
   end

   assign rd_addr = cur_q;
   assign act     = act_q;
   assign wake    = wake_q;

endmodule

// File: rtl/sburst_wmask.sv
module sburst_wmask #(
   parameter int LANES = 4
) (
   input  logic             wr_ok,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] bw_n,
   output logic [LANES-1:0] lane_we
);

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_we[i] = wr_ok & (~gw_n | (~bwe_n & ~bw_n[i]));
      end
   endgenerate

endmodule

// File: rtl/sburst_array.sv
module sburst_array #(
   parameter int ADDR_W    = 6,
   parameter int LANES     = 4,
   parameter int LANE_BITS = 9
) (
   input  logic                       clk,
   input  logic [LANES-1:0]           lane_we,
   input  logic [ADDR_W-1:0]          wa,
   input  logic [LANES*LANE_BITS-1:0] wdata,
   input  logic [ADDR_W-1:0]          ra,
   output logic [LANES*LANE_BITS-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_bank
         logic [LANE_BITS-1:0] bank [DEPTH];

         always_ff @(posedge clk) begin
            if (lane_we[i]) bank[wa] <= wdata[i*LANE_BITS +: LANE_BITS];
         end

         assign rdata[i*LANE_BITS +: LANE_BITS] = bank[ra];
      end
   endgenerate

endmodule

// File: rtl/sburst_sram.sv
module sburst_sram #(
   parameter int ADDR_W    = 6,
   parameter int LANES     = 4,
   parameter int LANE_BITS = 9,
   parameter int CNT_W     = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [ADDR_W-1:0]          addr,
   input  logic                       ce1_n,
   input  logic                       ce2,
   input  logic                       ce3_n,
   input  logic                       adsp_n,
   input  logic                       adsc_n,
   input  logic                       adv_n,
   input  logic                       gw_n,
   input  logic                       bwe_n,
   input  logic [LANES-1:0]           bw_n,
   input  logic                       oe_n,
   input  logic                       sleep,
   input  logic                       mode_ilv,
   input  logic [LANES*LANE_BITS-1:0] din,
   output logic [LANES*LANE_BITS-1:0] dout,
   output logic                       dout_en
);

   localparam int WORD_W = LANES * LANE_BITS;

   generate
      if (CNT_W < 1 || ADDR_W <= CNT_W) begin : g_bad_addr
         $error("sburst_sram: ADDR_W must exceed CNT_W and CNT_W must be at least 1");
      end
      if (LANES < 1 || LANE_BITS < 1) begin : g_bad_lane
         $error("sburst_sram: LANES and LANE_BITS must be positive");
      end
   endgenerate

   logic              wr_ok;
   logic [ADDR_W-1:0] wr_addr;
   logic [ADDR_W-1:0] rd_addr;
   logic              act;
   logic              wake;
   logic [LANES-1:0]  lane_we;
   logic [WORD_W-1:0] rdata;
   logic              wr_prev_q;

   sburst_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep   (sleep),
      .addr    (addr),
      .ce1_n   (ce1_n),
      .ce2     (ce2),
      .ce3_n   (ce3_n),
      .adsp_n  (adsp_n),
      .adsc_n  (adsc_n),
      .adv_n   (adv_n),
      .ilv     (mode_ilv),
      .wr_ok   (wr_ok),
      .wr_addr (wr_addr),
      .rd_addr (rd_addr),
      .act     (act),
      .wake    (wake)
   );

   sburst_wmask #(.LANES(LANES)) u_wmask (
      .wr_ok   (wr_ok),
      .gw_n    (gw_n),
      .bwe_n   (bwe_n),
      .bw_n    (bw_n),
      .lane_we (lane_we)
   );

   sburst_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_BITS(LANE_BITS)) u_array (
      .clk     (clk),
      .lane_we (lane_we),
      .wa      (wr_addr),
      .wdata   (din),
      .ra      (rd_addr),
      .rdata   (rdata)
   );

   // Remember whether the last awake edge wrote; sleep holds it.
   always_ff @(posedge clk) begin
      if (!rst_n)      wr_prev_q <= 1'b0;
      else if (!sleep) wr_prev_q <= |lane_we;
   end

   assign dout    = rdata;
   assign dout_en = ~oe_n & act & ~wake & ~wr_prev_q & ~sleep;

endmodule

// File: rtl/sburst_sram_chk.sv
module sburst_sram_chk #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int CNT_W  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sleep,
   input logic              oe_n,
   input logic              ce1_n,
   input logic              ce2,
   input logic              ce3_n,
   input logic              adsp_n,
   input logic              adsc_n,
   input logic              dout_en,
   input logic              act,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [LANES-1:0]  lane_we
);

   assert_wr_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && (|lane_we)) |=> !dout_en);

   assert_wake_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && !act && (!adsp_n || !adsc_n) && !ce1_n && ce2 && !ce3_n) |=> !dout_en);

   assert_desel_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && (!adsc_n || (!adsp_n && !ce1_n)) && !(!ce1_n && ce2 && !ce3_n))
      |=> (!dout_en && !act));

   assert_sleep_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ($stable(rd_addr) && $stable(act)));

   assert_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && act && adsp_n && adsc_n)
      |=> (rd_addr[ADDR_W-1:CNT_W] == $past(rd_addr[ADDR_W-1:CNT_W])));

   assert_oe_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dout_en);

endmodule

bind sburst_sram sburst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .sleep   (sleep),
   .oe_n    (oe_n),
   .ce1_n   (ce1_n),
   .ce2     (ce2),
   .ce3_n   (ce3_n),
   .adsp_n  (adsp_n),
   .adsc_n  (adsc_n),
   .dout_en (dout_en),
   .act     (act),
   .rd_addr (rd_addr),
   .lane_we (lane_we)
);

// File: tb/sburst_sram_test.sv
`timescale 1ns/1ps
module sburst_sram_test;

   localparam int AW = 6;
   localparam int NL = 4;
   localparam int LB = 9;
   localparam int WW = NL * LB;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          ce1_n, ce2, ce3_n, adsp_n, adsc_n, adv_n, gw_n, bwe_n;
   logic [NL-1:0] bw_n;
   logic          oe_n, sleep, mode_ilv;
   logic [WW-1:0] din;
   logic [WW-1:0] dout;
   logic          dout_en;

   logic [WW-1:0] refm [DEPTH];
   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sburst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_BITS(LB), .CNT_W(2)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
      .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .gw_n(gw_n), .bwe_n(bwe_n),
      .bw_n(bw_n), .oe_n(oe_n), .sleep(sleep), .mode_ilv(mode_ilv), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   function automatic logic [WW-1:0] pat(input int a);
      return (WW'(a) * 36'h0_0F1E_2D3C) ^ 36'hA_5C3A_96E1;
   endfunction

   function automatic int ord(input int s, input int k, input bit ilv);
      return ilv ? (s ^ k) : ((s + k) % 4);
   endfunction

   task automatic idle();
      adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1;
      bw_n = '1; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; oe_n = 1'b0; sleep = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string r, input logic [WW-1:0] act, input logic [WW-1:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic chk_en(input string r, input logic exp);
      chk(r, WW'(dout_en), WW'(exp));
   endtask

   // Controller-strobe start edge carrying write controls.
   task automatic cwrite(input int a, input logic [WW-1:0] d, input logic g, input logic be,
                         input logic [NL-1:0] m);
      addr = AW'(a); adsc_n = 1'b0; gw_n = g; bwe_n = be; bw_n = m; din = d;
      if (!g) refm[a] = d;
      else if (!be) begin
         for (int i = 0; i < NL; i++)
            if (!m[i]) refm[a][i*LB +: LB] = d[i*LB +: LB];
      end
      tick();
      idle();
   endtask

   task automatic start(input int a, input bit use_p);
      addr = AW'(a);
      if (use_p) adsp_n = 1'b0; else adsc_n = 1'b0;
      tick();
      idle();
   endtask

   task automatic desel();
      adsc_n = 1'b0; ce2 = 1'b0;
      tick();
      idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      idle();
      mode_ilv = 1'b0; addr = '0; din = '0; rst_n = 1'b0;
      repeat (3) tick();
      chk_en("R4 reset deselected", 1'b0);
      rst_n = 1'b1;
      tick();
      chk_en("R4 idle after reset", 1'b0);

      // fill the array with global writes
      for (int a = 0; a < DEPTH; a++) cwrite(a, pat(a), 1'b0, 1'b1, 4'hF);

      // R6 / R7 / R1: every start offset, both orders, wrap after four advances
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 4; s++) begin
            int b;
            b = 20 + 4 * m;
            mode_ilv = m[0];
            desel();
            start(b + s, s[0]);
            chk_en("R1 first cycle after leaving deselect", 1'b0);
            tick();
            chk_en("R1 data enabled", 1'b1);
            chk("R1 loaded word", dout, refm[b + s]);
            for (int k = 1; k <= 4; k++) begin
               adv_n = 1'b0;
               tick();
               adv_n = 1'b1;
               if (m == 0) chk("R6 linear burst", dout, refm[b + ord(s, k % 4, 1'b0)]);
               else        chk("R7 interleaved burst", dout, refm[b + ord(s, k % 4, 1'b1)]);
            end
         end
      end
      mode_ilv = 1'b0;

      // R9 / R10: every byte mask
      for (int m = 0; m < 16; m++) begin
         cwrite(32 + m, pat(100 + m), 1'b1, 1'b0, 4'(m));
         if (m != 15) chk_en("R10 output blank after write", 1'b0);
         start(32 + m, 1'b0);
         chk_en("R9 readback enabled", 1'b1);
         chk("R9 lane mask write", dout, refm[32 + m]);
      end
      cwrite(50, ~refm[50], 1'b1, 1'b1, 4'h0);
      start(50, 1'b0);
      chk("R9 no write without byte enable", dout, refm[50]);

      // R8: global write overrides byte selects
      cwrite(51, pat(777), 1'b0, 1'b1, 4'h5);
      start(51, 1'b0);
      chk("R8 global write all lanes", dout, pat(777));

      // R2: processor strobe wins and ignores write controls
      addr = AW'(12); adsp_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0; din = ~refm[12];
      tick();
      idle();
      chk_en("R2 processor start is a read", 1'b1);
      chk("R2 memory untouched", dout, refm[12]);

      // R13: write on a continuing edge goes to the advanced address
      start(9, 1'b0);
      adv_n = 1'b0; gw_n = 1'b0; din = pat(555); refm[10] = pat(555);
      tick();
      idle();
      start(10, 1'b0);
      chk("R13 write to advanced address", dout, pat(555));
      start(9, 1'b0);
      chk("R13 neighbour unchanged", dout, refm[9]);

      // R12: sleep freezes everything
      start(17, 1'b1);
      tick();
      sleep = 1'b1; adv_n = 1'b0; gw_n = 1'b0; din = '0;
      tick();
      chk_en("R12 blank while asleep", 1'b0);
      tick();
      tick();
      idle();
      #1;
      chk_en("R12 enabled after wake", 1'b1);
      chk("R12 position and contents kept", dout, refm[17]);
      adv_n = 1'b0;
      tick();
      idle();
      chk("R12 burst resumes from kept position", dout, refm[18]);

      // R11: asynchronous output enable
      oe_n = 1'b1;
      #1;
      chk_en("R11 oe_n high blanks", 1'b0);
      oe_n = 1'b0;
      #1;
      chk_en("R11 oe_n low restores", 1'b1);

      // R5: enables 2 and 3 ignored between strobes
      start(4, 1'b0);
      ce2 = 1'b0; ce3_n = 1'b1; adv_n = 1'b0;
      tick();
      idle();
      chk_en("R5 burst continues", 1'b1);
      chk("R5 burst data", dout, refm[5]);

      // R3: processor strobe ignored with ce1_n high
      start(24, 1'b0);
      adsp_n = 1'b0; ce1_n = 1'b1; adv_n = 1'b0;
      tick();
      idle();
      chk("R3 ignored strobe continues burst", dout, refm[25]);
      adsp_n = 1'b0; adsc_n = 1'b0; ce1_n = 1'b1;
      tick();
      idle();
      chk_en("R3 controller strobe deselects", 1'b0);

      // R4: deselected device ignores advance
      start(28, 1'b0);
      desel();
      chk_en("R4 deselected", 1'b0);
      adv_n = 1'b0;
      tick();
      tick();
      idle();
      chk_en("R4 advance while deselected", 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule